// File: doc/BRIEF.md
# UART interrupt priority controller

This block gathers the interrupt events of a UART and presents them to software as one interrupt request and one identification byte. The surrounding logic owns the register decoder, the FIFOs and the serializer. It reaches this block only through single-cycle strobes. Event strobes report a line error, receive data, a character timeout, an empty transmit holding register or a modem line change. Read strobes report that software has read the identification, line status or modem status register.

Each event sets a pending flag, and the flag stays set until its own clear condition. A 4-bit enable register masks the pending flags. A fixed priority chain then picks one enabled source and turns it into an identification code. The interrupt request is registered and is only driven active when the output-gate bit of the modem control register is set. The block also keeps the line error bits and the modem delta bits, and clears them when their registers are read.

Top module: `uart_irq_prio`

## Requirements
- R1: When several enabled sources are pending, the one reported is the highest in this order: line status, then character timeout, then receive data, then transmitter empty, then modem status.
- R2: `ident_o[5:0]` is 0x06 for line status, 0x0C for timeout, 0x04 for receive data, 0x02 for transmitter empty, 0x00 for modem status, and 0x01 when no enabled source is pending.
- R3: Enable bit 0 admits both receive data and timeout, bit 1 admits transmitter empty, bit 2 admits line status and bit 3 admits modem status. `ier_o` reads back the 4 stored enable bits.
- R4: `irq_o` is high exactly one cycle after a cycle in which an enabled source was pending and `mcr_out2` was 1. In every other case it is low.
- R5: A cycle with `ident_rd` high while `ident_o[5:0]` is 0x02 clears the transmitter-empty flag. An identification read that shows any other code leaves that flag pending.
- R6: While `fifo_en` is 1, `ident_o[7:6]` reads 2'b11. Otherwise these bits read 2'b00.
- R7: A write to the enable register with data bit 1 set while `thr_empty` is 1 sets the transmitter-empty flag at that clock edge. With `thr_empty` at 0, the same write does not set it.
- R8: Line error bits arriving on `line_err_set` accumulate into `line_err_o` and raise the line-status flag. A cycle with `line_rd` high clears both.
- R9: Modem delta bits arriving on `modem_delta_set` accumulate into `modem_delta_o` and raise the modem-status flag. A cycle with `modem_rd` high clears both.
- R10: Synchronous active-high reset clears every pending flag, the enable register, the error and delta bits and `irq_o`, so `ident_o[5:0]` reads 0x01.
- R11: If a set and a clear reach the same pending flag in the same cycle, the flag ends up set.
- R12: A source is latched even while it is disabled. Enabling it later reports it with no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| ier_o | output | 4 | Enable register contents |
| mcr_out2 | input | 1 | Output-gate bit from the modem control register |
| fifo_en | input | 1 | FIFO mode active |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| line_err_set | input | 4 | Line error bits detected this cycle |
| rx_avail_set | input | 1 | Receive data reached the trigger point |
| rx_avail_clr | input | 1 | Receive data drained below the trigger point |
| char_tmo_set | input | 1 | Character timeout expired |
| char_tmo_clr | input | 1 | Character timeout withdrawn |
| tx_empty_set | input | 1 | Holding register became empty |
| tx_load_clr | input | 1 | Holding register was written |
| modem_delta_set | input | 4 | Modem line change bits detected this cycle |
| ident_rd | input | 1 | Identification register read strobe |
| line_rd | input | 1 | Line status register read strobe |
| modem_rd | input | 1 | Modem status register read strobe |
| ident_o | output | 8 | Identification register read value |
| line_err_o | output | 4 | Accumulated line error bits |
| modem_delta_o | output | 4 | Accumulated modem delta bits |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit enable register and 4-bit error and delta fields. These values make every enable mask and every mix of the five sources small enough to drive directly. The vector walk therefore covers each priority position, each single enable bit and the gated output. The directed tests cover the single-cycle interactions that priority cannot show: a read that clears a flag versus one that must not, a set and a clear meeting on the same edge, and the one-cycle delay of the registered request.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int SRC_N   = 5;
    localparam int IER_W   = 4;
    localparam int FLAG_W  = 4;
    localparam int CODE_W  = 6;
    localparam int IDENT_W = 8;

    // Enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [2:0] {
        SRC_LINE,
        SRC_TMO,
        SRC_RX,
        SRC_TX,
        SRC_MODEM,
        SRC_NONE
    } src_e;

    // Field order matches the flag vector: bit 4 = line ... bit 0 = modem
    typedef struct packed {
        logic line;
        logic tmo;
        logic rx;
        logic tx;
        logic modem;
    } pend_t;

    typedef struct packed {
        logic              valid;
        src_e              src;
        logic [CODE_W-1:0] code;
    } pick_t;

    localparam logic [CODE_W-1:0] CODE_LINE  = 6'h06;
    localparam logic [CODE_W-1:0] CODE_TMO   = 6'h0C;
    localparam logic [CODE_W-1:0] CODE_RX    = 6'h04;
    localparam logic [CODE_W-1:0] CODE_TX    = 6'h02;
    localparam logic [CODE_W-1:0] CODE_MODEM = 6'h00;
    localparam logic [CODE_W-1:0] CODE_NONE  = 6'h01;

    function automatic logic [CODE_W-1:0] code_of(input src_e s);
        case (s)
            SRC_LINE:  return CODE_LINE;
            SRC_TMO:   return CODE_TMO;
            SRC_RX:    return CODE_RX;
            SRC_TX:    return CODE_TX;
            SRC_MODEM: return CODE_MODEM;
            default:   return CODE_NONE;
        endcase
    endfunction

    function automatic pick_t pick(input pend_t p, input logic [IER_W-1:0] en);
        pick_t r;
        src_e  s;
        if (p.line && en[EN_LINE])        s = SRC_LINE;
        else if (p.tmo && en[EN_RX])      s = SRC_TMO;
        else if (p.rx && en[EN_RX])       s = SRC_RX;
        else if (p.tx && en[EN_TX])       s = SRC_TX;
        else if (p.modem && en[EN_MODEM]) s = SRC_MODEM;
        else                              s = SRC_NONE;
        r.valid = (s != SRC_NONE);
        r.src   = s;
        r.code  = code_of(s);
        return r;
    endfunction

endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    // One pending flag per source; a set on the same edge beats a clear
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)           q_o[g] <= 1'b0;
            else if (set_i[g]) q_o[g] <= 1'b1;
            else if (clr_i[g]) q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    // Bits accumulate until a read; fresh bits survive a same-cycle read
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= set_i | (q_o & {W{~clr_i}});
    end
endmodule

// File: rtl/uart_irq_select.sv
module uart_irq_select
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pend_t            pend_i,
    input  logic [IER_W-1:0] en_i,
    input  logic             gate_i,
    output pick_t            pick_o,
    output logic             irq_o
);
    always_comb pick_o = pick(pend_i, en_i);

    // Registered request keeps decode glitches off the output pin
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pick_o.valid & gate_i;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ier_wr,
    input  logic [IER_W-1:0]   ier_wdata,
    output logic [IER_W-1:0]   ier_o,
    input  logic               mcr_out2,
    input  logic               fifo_en,
    input  logic               thr_empty,
    input  logic [FLAG_W-1:0]  line_err_set,
    input  logic               rx_avail_set,
    input  logic               rx_avail_clr,
    input  logic               char_tmo_set,
    input  logic               char_tmo_clr,
    input  logic               tx_empty_set,
    input  logic               tx_load_clr,
    input  logic [FLAG_W-1:0]  modem_delta_set,
    input  logic               ident_rd,
    input  logic               line_rd,
    input  logic               modem_rd,
    output logic [IDENT_W-1:0] ident_o,
    output logic [FLAG_W-1:0]  line_err_o,
    output logic [FLAG_W-1:0]  modem_delta_o,
    output logic               irq_o
);
    localparam int HI_W = IDENT_W - CODE_W;

    logic [IER_W-1:0] ier_q;
    pend_t            set_s, clr_s, pend_q;
    logic [SRC_N-1:0] pend_v;
    pick_t            sel;

    always_ff @(posedge clk) begin
        if (rst)         ier_q <= '0;
        else if (ier_wr) ier_q <= ier_wdata;
    end
    assign ier_o = ier_q;

    always_comb begin
        set_s.line  = |line_err_set;
        set_s.tmo   = char_tmo_set;
        set_s.rx    = rx_avail_set;
        set_s.tx    = tx_empty_set | (ier_wr & ier_wdata[EN_TX] & thr_empty);
        set_s.modem = |modem_delta_set;

        clr_s.line  = line_rd;
        clr_s.tmo   = char_tmo_clr;
        clr_s.rx    = rx_avail_clr;
        clr_s.tx    = tx_load_clr | (ident_rd & (sel.src == SRC_TX));
        clr_s.modem = modem_rd;
    end

    uart_irq_flags #(.N(SRC_N)) i_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_s),
        .clr_i (clr_s),
        .q_o   (pend_v)
    );
    assign pend_q = pend_t'(pend_v);

    uart_irq_sticky #(.W(FLAG_W)) i_line_bits (
        .clk   (clk),
        .rst   (rst),
        .set_i (line_err_set),
        .clr_i (line_rd),
        .q_o   (line_err_o)
    );

    uart_irq_sticky #(.W(FLAG_W)) i_modem_bits (
        .clk   (clk),
        .rst   (rst),
        .set_i (modem_delta_set),
        .clr_i (modem_rd),
        .q_o   (modem_delta_o)
    );

    uart_irq_select i_select (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_q),
        .en_i   (ier_q),
        .gate_i (mcr_out2),
        .pick_o (sel),
        .irq_o  (irq_o)
    );

    assign ident_o = {{HI_W{fifo_en}}, sel.code};

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ier_wr,
    input logic [3:0] ier_wdata,
    input logic       mcr_out2,
    input logic       thr_empty,
    input logic [3:0] line_err_set,
    input logic       tx_empty_set,
    input logic [3:0] modem_delta_set,
    input logic       ident_rd,
    input logic       line_rd,
    input logic       modem_rd,
    input logic [7:0] ident_o,
    input logic [3:0] line_err_o,
    input logic [3:0] modem_delta_o,
    input logic       irq_o
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ident_o[5:0] == 6'h01 && !irq_o)); // R10

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(mcr_out2)); // R4

    AST_LINE_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        $past(line_rd && line_err_set == 4'h0) |-> line_err_o == 4'h0); // R8

    AST_MODEM_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        $past(modem_rd && modem_delta_set == 4'h0) |-> modem_delta_o == 4'h0); // R9

    AST_TX_ID_RD_CLR: assert property (@(posedge clk) disable iff (rst)
        $past(ident_rd && ident_o[5:0] == 6'h02 && !tx_empty_set
              && !(ier_wr && ier_wdata[1] && thr_empty))
        |-> ident_o[5:0] != 6'h02); // R5
endmodule

bind uart_irq_prio uart_irq_chk i_chk (.*);

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // {line,tmo,rx,tx,modem}[18:14], enable[13:10], gate[9], ident[8:1], irq[0]
    localparam logic [18:0] VEC [NVEC] = '{
        {5'b11111, 4'hF, 1'b1, 8'h06, 1'b1},  // R1 line on top
        {5'b01111, 4'hF, 1'b1, 8'h0C, 1'b1},  // R1 timeout next
        {5'b00111, 4'hF, 1'b1, 8'h04, 1'b1},  // R1 receive next
        {5'b00011, 4'hF, 1'b1, 8'h02, 1'b1},  // R1 tx next
        {5'b00001, 4'hF, 1'b1, 8'h00, 1'b1},  // R2 modem code
        {5'b11111, 4'h0, 1'b1, 8'h01, 1'b0},  // R3 all masked
        {5'b11111, 4'h1, 1'b1, 8'h0C, 1'b1},  // R3 bit0 admits timeout
        {5'b10110, 4'h2, 1'b1, 8'h02, 1'b1},  // R3 bit1 only
        {5'b11111, 4'h8, 1'b1, 8'h00, 1'b1},  // R3 bit3 only
        {5'b11111, 4'h4, 1'b0, 8'h06, 1'b0},  // R4 gate low
        {5'b00101, 4'hB, 1'b1, 8'h04, 1'b1}   // R3 bit2 off, rx wins
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       ier_wr;
    logic [3:0] ier_wdata;
    logic [3:0] ier_o;
    logic       mcr_out2, fifo_en, thr_empty;
    logic [3:0] line_err_set;
    logic       rx_avail_set, rx_avail_clr, char_tmo_set, char_tmo_clr;
    logic       tx_empty_set, tx_load_clr;
    logic [3:0] modem_delta_set;
    logic       ident_rd, line_rd, modem_rd;
    logic [7:0] ident_o;
    logic [3:0] line_err_o, modem_delta_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_prio i_uart_irq_prio (.*);

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ier_wr = 0; ier_wdata = 0;
        line_err_set = 0; rx_avail_set = 0; rx_avail_clr = 0;
        char_tmo_set = 0; char_tmo_clr = 0; tx_empty_set = 0; tx_load_clr = 0;
        modem_delta_set = 0; ident_rd = 0; line_rd = 0; modem_rd = 0;
    endtask

    task automatic clear_all();
        line_rd = 1; modem_rd = 1; rx_avail_clr = 1; char_tmo_clr = 1;
        tx_load_clr = 1; ier_wr = 1; ier_wdata = 4'h0;
        tick();
        idle_inputs();
    endtask

    task automatic write_ier(input logic [3:0] v);
        ier_wr = 1; ier_wdata = v;
        tick();
        ier_wr = 0; ier_wdata = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        mcr_out2 = 1; fifo_en = 0; thr_empty = 0;
        rst = 1;
        tick(); tick(); tick();
        // R10 reset state
        chk("R10 ident", ident_o, 8'h01);
        chk("R10 irq", {7'h0, irq_o}, 8'h00);
        chk("R10 ier", {4'h0, ier_o}, 8'h00);
        chk("R10 line bits", {4'h0, line_err_o}, 8'h00);
        chk("R10 modem bits", {4'h0, modem_delta_o}, 8'h00);
        rst = 0;
        tick();

        // Vector walk: R1 R2 R3 R4
        for (int i = 0; i < NVEC; i++) begin
            clear_all();
            line_err_set    = VEC[i][18] ? 4'b0010 : 4'b0000;
            char_tmo_set    = VEC[i][17];
            rx_avail_set    = VEC[i][16];
            tx_empty_set    = VEC[i][15];
            modem_delta_set = VEC[i][14] ? 4'b0001 : 4'b0000;
            ier_wr = 1; ier_wdata = VEC[i][13:10];
            mcr_out2 = VEC[i][9];
            tick();
            idle_inputs();
            chk($sformatf("R1/R2/R3 ident vec %0d", i), ident_o, VEC[i][8:1]);
            tick();
            chk($sformatf("R4 irq vec %0d", i), {7'h0, irq_o}, {7'h0, VEC[i][0]});
        end
        mcr_out2 = 1;

        // R3 enable readback
        clear_all();
        write_ier(4'hA);
        chk("R3 ier readback", {4'h0, ier_o}, 8'h0A);

        // R5 ident read showing tx clears it
        clear_all();
        tx_empty_set = 1; ier_wr = 1; ier_wdata = 4'h2;
        tick(); idle_inputs();
        chk("R5 tx shown", ident_o, 8'h02);
        ident_rd = 1;
        tick(); ident_rd = 0;
        chk("R5 tx cleared by ident read", ident_o, 8'h01);

        // R5 ident read showing line leaves tx pending
        clear_all();
        line_err_set = 4'b0001; tx_empty_set = 1; ier_wr = 1; ier_wdata = 4'h6;
        tick(); idle_inputs();
        ident_rd = 1;
        tick(); ident_rd = 0;
        chk("R5 line still shown", ident_o, 8'h06);
        line_rd = 1;
        tick(); line_rd = 0;
        chk("R5 tx kept after other read", ident_o, 8'h02);

        // R7 enable write with empty holding register
        clear_all();
        thr_empty = 1;
        write_ier(4'h2);
        chk("R7 tx raised", ident_o, 8'h02);
        clear_all();
        thr_empty = 0;
        write_ier(4'h2);
        chk("R7 no raise when busy", ident_o, 8'h01);

        // R11 set beats clear
        clear_all();
        rx_avail_set = 1; rx_avail_clr = 1; ier_wr = 1; ier_wdata = 4'h1;
        tick(); idle_inputs();
        chk("R11 set wins", ident_o, 8'h04);

        // R12 latched while disabled, R4 latency, R9 modem read
        clear_all();
        modem_delta_set = 4'b0100;
        tick(); idle_inputs();
        chk("R12 disabled hidden", ident_o, 8'h01);
        chk("R9 delta bits", {4'h0, modem_delta_o}, 8'h04);
        write_ier(4'h8);
        chk("R12 shown once enabled", ident_o, 8'h00);
        chk("R4 irq not yet", {7'h0, irq_o}, 8'h00);
        tick();
        chk("R4 irq after one cycle", {7'h0, irq_o}, 8'h01);
        modem_rd = 1;
        tick(); modem_rd = 0;
        chk("R9 delta cleared", {4'h0, modem_delta_o}, 8'h00);
        chk("R9 flag cleared", ident_o, 8'h01);

        // R8 line bits accumulate and clear
        clear_all();
        write_ier(4'h4);
        line_err_set = 4'b0101; tick();
        line_err_set = 4'b1000; tick();
        line_err_set = 4'b0000;
        chk("R8 accumulate", {4'h0, line_err_o}, 8'h0D);
        chk("R8 flag shown", ident_o, 8'h06);
        line_rd = 1;
        tick(); line_rd = 0;
        chk("R8 bits cleared", {4'h0, line_err_o}, 8'h00);
        chk("R8 flag cleared", ident_o, 8'h01);

        // R6 FIFO bits
        fifo_en = 1;
        #1;
        chk("R6 idle with fifo", ident_o, 8'hC1);
        line_err_set = 4'b0010;
        tick(); line_err_set = 0;
        chk("R6 line with fifo", ident_o, 8'hC6);
        fifo_en = 0;
        #1;
        chk("R6 fifo off", ident_o, 8'h06);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule